// File: doc/BRIEF.md
# Minimum-Basis Min-Max Check Message Builder

This block produces the outgoing message of one check-node edge in a non-binary decoder working over GF(2^SYM_W). It receives one pruned reliability value for each nonzero field symbol, the check's syndrome symbol and the hard decision of the edge. A lower value means a more reliable symbol. The block orders the nonzero symbols by reliability. It then greedily keeps the most reliable symbols that are linearly independent over GF(2), until it holds a basis of SYM_W symbols. Every field value has a unique XOR decomposition over that basis. The value's reliability is the largest reliability among the basis symbols it uses, and the zero value gets zero.

The resulting vector is re-indexed by the syndrome and the hard decision before it leaves. Each job arrives as one parallel word on a valid/ready input. The results leave on a valid/ready output, one field element per beat, in ascending symbol order. The last beat is flagged. Only one job is in flight at a time.

Top module: `mmb_minmax_basis`

## Requirements
- R1: While reset is asserted and right after it, out_valid and out_last are 0 and in_ready is 1.
- R2: in_ready is 0 from the cycle after a job is accepted until the final output beat has been accepted. It returns to 1 in the cycle after that last beat.
- R3: After the rising edge that accepts a job, out_valid first goes high following the third rising edge that comes after it.
- R4: A job produces exactly 2^SYM_W output beats. out_sym counts 0, 1, ..., 2^SYM_W-1, and out_llr on each beat is the value for field element out_sym.
- R5: out_last is 1 only on the beat with out_sym = 2^SYM_W-1.
- R6: While out_valid is 1 and out_ready is 0, out_sym and out_llr hold their values.
- R7: Basis candidates are taken in ascending order of their reliability value. The input field for symbol b (b from 1 to 2^SYM_W-1) is in_llr[(b-1)*LLR_W +: LLR_W].
- R8: A candidate that is already an XOR combination of the symbols chosen so far is skipped.
- R9: Before re-indexing, the value for symbol 0 is 0. For a nonzero symbol it is the maximum reliability among the basis symbols whose XOR gives that symbol.
- R10: The beat for element a carries the pre-remap value of symbol a XOR in_syn XOR in_hard, using the in_syn and in_hard captured with the job.
- R11: in_valid and the input fields have no effect while in_ready is 0. A word held on the input during a busy job is taken only once in_ready returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input job present |
| in_ready | output | 1 | Block can take a job |
| in_llr | input | (2^SYM_W-1)*LLR_W | Reliabilities of nonzero symbols 1.. upward from bit 0 |
| in_syn | input | SYM_W | Check syndrome symbol |
| in_hard | input | SYM_W | Hard-decision symbol of this edge |
| out_valid | output | 1 | Output beat present |
| out_ready | input | 1 | Consumer takes the beat |
| out_sym | output | SYM_W | Field element of this beat |
| out_llr | output | LLR_W | Reliability for out_sym |
| out_last | output | 1 | Final beat of the job |

## Verification
The final output handshake and the acceptance of the next job compete for the same boundary. The bench holds a second job on the input through the whole of a busy job. It checks that in_ready stays low on every beat, that the first job's beats are unchanged, and that in_ready is high in the cycle right after the final beat. The second job's output must then match its own inputs. The output stall and the final beat are also combined: out_ready is held low on the flagged beat to show that both the value and out_last wait.

// File: rtl/mmb_pkg.sv
package mmb_pkg;
  // Sequencing of one job through the block.
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SORT,
    ST_PICK,
    ST_MAP,
    ST_EMIT
  } mmb_state_e;
endpackage

// File: rtl/mmb_sort.sv
// Stable odd-even transposition network over the nonzero symbols.
module mmb_sort #(
  parameter int SYM_W = 2,
  parameter int LLR_W = 6,
  localparam int NUM  = (1 << SYM_W) - 1
) (
  input  logic [NUM*LLR_W-1:0] llr_in,
  output logic [NUM*SYM_W-1:0] sym_out,
  output logic [NUM*LLR_W-1:0] llr_out
);
  logic [SYM_W-1:0] w_sym [NUM];
  logic [LLR_W-1:0] w_llr [NUM];

  always_comb begin
    logic [SYM_W-1:0] t_sym;
    logic [LLR_W-1:0] t_llr;
    t_sym = '0;
    t_llr = '0;
    for (int k = 0; k < NUM; k++) begin
      w_sym[k] = SYM_W'(k + 1);
      w_llr[k] = llr_in[k*LLR_W +: LLR_W];
    end
    // NUM rounds guarantee a sorted result; strict compare keeps ties in order.
    for (int r = 0; r < NUM; r++) begin
      for (int i = 0; i < NUM - 1; i++) begin
        if (((i % 2) == (r % 2)) && (w_llr[i] > w_llr[i+1])) begin
          t_sym      = w_sym[i];
          t_llr      = w_llr[i];
          w_sym[i]   = w_sym[i+1];
          w_llr[i]   = w_llr[i+1];
          w_sym[i+1] = t_sym;
          w_llr[i+1] = t_llr;
        end
      end
    end
  end

  for (genvar k = 0; k < NUM; k++) begin : g_pack
    assign sym_out[k*SYM_W +: SYM_W] = w_sym[k];
    assign llr_out[k*LLR_W +: LLR_W] = w_llr[k];
  end
endmodule

// File: rtl/mmb_basis.sv
// Greedy GF(2) basis selection over sorted candidates using a span bitmap.
module mmb_basis #(
  parameter int SYM_W = 2,
  parameter int LLR_W = 6,
  localparam int Q    = 1 << SYM_W,
  localparam int NUM  = Q - 1
) (
  input  logic [NUM*SYM_W-1:0]   srt_sym,
  input  logic [NUM*LLR_W-1:0]   srt_llr,
  output logic [SYM_W*SYM_W-1:0] bas_sym,
  output logic [SYM_W*LLR_W-1:0] bas_llr
);
  always_comb begin
    logic [Q-1:0]     span;
    logic [Q-1:0]     grow;
    logic [SYM_W-1:0] cand;
    int               cnt;
    span    = Q'(1);
    grow    = '0;
    cand    = '0;
    cnt     = 0;
    bas_sym = '0;
    bas_llr = '0;
    for (int k = 0; k < NUM; k++) begin
      cand = srt_sym[k*SYM_W +: SYM_W];
      if ((cnt < SYM_W) && !span[cand]) begin
        bas_sym[cnt*SYM_W +: SYM_W] = cand;
        bas_llr[cnt*LLR_W +: LLR_W] = srt_llr[k*LLR_W +: LLR_W];
        grow = span;
        for (int v = 0; v < Q; v++) begin
          if (span[v]) grow[SYM_W'(v) ^ cand] = 1'b1;
        end
        span = grow;
        cnt  = cnt + 1;
      end
    end
  end
endmodule

// File: rtl/mmb_expand.sv
// Max-over-decomposition for every field value, then syndrome re-indexing.
module mmb_expand #(
  parameter int SYM_W = 2,
  parameter int LLR_W = 6,
  localparam int Q    = 1 << SYM_W
) (
  input  logic [SYM_W*SYM_W-1:0] bas_sym,
  input  logic [SYM_W*LLR_W-1:0] bas_llr,
  input  logic [SYM_W-1:0]       key,
  output logic [Q*LLR_W-1:0]     vec_llr
);
  logic [LLR_W-1:0] vhat [Q];

  always_comb begin
    logic [SYM_W-1:0] acc_sym;
    logic [LLR_W-1:0] acc_max;
    acc_sym = '0;
    acc_max = '0;
    for (int v = 0; v < Q; v++) vhat[v] = '0;
    for (int m = 1; m < Q; m++) begin
      acc_sym = '0;
      acc_max = '0;
      for (int b = 0; b < SYM_W; b++) begin
        if (((m >> b) & 1) != 0) begin
          acc_sym = acc_sym ^ bas_sym[b*SYM_W +: SYM_W];
          if (bas_llr[b*LLR_W +: LLR_W] > acc_max) acc_max = bas_llr[b*LLR_W +: LLR_W];
        end
      end
      vhat[acc_sym] = acc_max;
    end
  end

  for (genvar a = 0; a < Q; a++) begin : g_remap
    assign vec_llr[a*LLR_W +: LLR_W] = vhat[SYM_W'(a) ^ key];
  end
endmodule

// File: rtl/mmb_minmax_basis.sv
// Top: capture, sort, pick basis, expand, then stream one element per beat.
// rst_n is asserted asynchronously; its release is expected synchronous to clk.
module mmb_minmax_basis #(
  parameter int SYM_W = 2,
  parameter int LLR_W = 6,
  localparam int Q    = 1 << SYM_W,
  localparam int NUM  = Q - 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [NUM*LLR_W-1:0] in_llr,
  input  logic [SYM_W-1:0]     in_syn,
  input  logic [SYM_W-1:0]     in_hard,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [SYM_W-1:0]     out_sym,
  output logic [LLR_W-1:0]     out_llr,
  output logic                 out_last
);
  import mmb_pkg::*;

  localparam logic [SYM_W-1:0] LAST_IDX = SYM_W'(Q - 1);

  mmb_state_e state_q, state_d;

  logic [NUM*LLR_W-1:0]   cap_llr_q;
  logic [SYM_W-1:0]       key_q;
  logic [NUM*SYM_W-1:0]   srt_sym_d, srt_sym_q;
  logic [NUM*LLR_W-1:0]   srt_llr_d, srt_llr_q;
  logic [SYM_W*SYM_W-1:0] bas_sym_d, bas_sym_q;
  logic [SYM_W*LLR_W-1:0] bas_llr_d, bas_llr_q;
  logic [Q*LLR_W-1:0]     vec_d, vec_q;
  logic [SYM_W-1:0]       idx_q, idx_d;

  logic cap_en, srt_en, bas_en, vec_en, idx_en, beat_done;

  mmb_sort #(.SYM_W(SYM_W), .LLR_W(LLR_W)) u_sort (
    .llr_in  (cap_llr_q),
    .sym_out (srt_sym_d),
    .llr_out (srt_llr_d)
  );

  mmb_basis #(.SYM_W(SYM_W), .LLR_W(LLR_W)) u_basis (
    .srt_sym (srt_sym_q),
    .srt_llr (srt_llr_q),
    .bas_sym (bas_sym_d),
    .bas_llr (bas_llr_d)
  );

  mmb_expand #(.SYM_W(SYM_W), .LLR_W(LLR_W)) u_expand (
    .bas_sym (bas_sym_q),
    .bas_llr (bas_llr_q),
    .key     (key_q),
    .vec_llr (vec_d)
  );

  assign beat_done = (state_q == ST_EMIT) && out_ready;

  // Next state and enables.
  always_comb begin
    state_d = state_q;
    cap_en  = 1'b0;
    srt_en  = 1'b0;
    bas_en  = 1'b0;
    vec_en  = 1'b0;
    idx_en  = 1'b0;
    idx_d   = idx_q;
    case (state_q)
      ST_IDLE: begin
        if (in_valid) begin
          cap_en  = 1'b1;
          state_d = ST_SORT;
        end
      end
      ST_SORT: begin
        srt_en  = 1'b1;
        state_d = ST_PICK;
      end
      ST_PICK: begin
        bas_en  = 1'b1;
        state_d = ST_MAP;
      end
      ST_MAP: begin
        vec_en  = 1'b1;
        idx_en  = 1'b1;
        idx_d   = '0;
        state_d = ST_EMIT;
      end
      ST_EMIT: begin
        if (beat_done) begin
          idx_en = 1'b1;
          idx_d  = idx_q + 1'b1;
          if (idx_q == LAST_IDX) state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // Registers.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      cap_llr_q <= '0;
      key_q     <= '0;
      srt_sym_q <= '0;
      srt_llr_q <= '0;
      bas_sym_q <= '0;
      bas_llr_q <= '0;
      vec_q     <= '0;
      idx_q     <= '0;
    end else begin
      state_q <= state_d;
      if (cap_en) begin
        cap_llr_q <= in_llr;
        key_q     <= in_syn ^ in_hard;
      end
      if (srt_en) begin
        srt_sym_q <= srt_sym_d;
        srt_llr_q <= srt_llr_d;
      end
      if (bas_en) begin
        bas_sym_q <= bas_sym_d;
        bas_llr_q <= bas_llr_d;
      end
      if (vec_en) vec_q <= vec_d;
      if (idx_en) idx_q <= idx_d;
    end
  end

  assign in_ready  = (state_q == ST_IDLE);
  assign out_valid = (state_q == ST_EMIT);
  assign out_sym   = idx_q;
  assign out_llr   = vec_q[idx_q*LLR_W +: LLR_W];
  assign out_last  = out_valid && (idx_q == LAST_IDX);
endmodule

// File: rtl/mmb_chk.sv
module mmb_chk #(
  parameter int SYM_W = 2,
  parameter int LLR_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [SYM_W-1:0] in_syn,
  input logic [SYM_W-1:0] in_hard,
  input logic             out_valid,
  input logic             out_ready,
  input logic [SYM_W-1:0] out_sym,
  input logic [LLR_W-1:0] out_llr,
  input logic             out_last
);
  logic             took;
  logic [SYM_W-1:0] seen_key_q;

  assign took = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_key_q <= '0;
    else if (took) seen_key_q <= in_syn ^ in_hard;
  end

  p_busy_blocks_input_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  p_first_beat_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(took, 4));

  p_first_beat_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> (out_sym == '0));

  p_beat_steps_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !out_last) |=> (out_valid && (out_sym == $past(out_sym) + 1'b1)));

  p_last_on_top_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> (out_valid && (&out_sym)));

  p_stall_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_sym) && $stable(out_llr) && $stable(out_last)));

  p_key_slot_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (out_sym == seen_key_q)) |-> (out_llr == '0));
endmodule

bind mmb_minmax_basis mmb_chk #(.SYM_W(SYM_W), .LLR_W(LLR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_syn    (in_syn),
  .in_hard   (in_hard),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_sym   (out_sym),
  .out_llr   (out_llr),
  .out_last  (out_last)
);

// File: tb/sim_mmb_minmax_basis.sv
module sim_mmb_minmax_basis;
  localparam int SYM_W = 2;
  localparam int LLR_W = 6;
  localparam int Q     = 1 << SYM_W;
  localparam int NUM   = Q - 1;
  localparam int VEC_W = NUM*LLR_W + 2*SYM_W;
  localparam int NV    = 8;

  // Each vector: {llr sym3, llr sym2, llr sym1, syndrome, hard}
  localparam logic [VEC_W-1:0] VECS [NV] = '{
    {6'd9,  6'd3,  6'd5,  2'd0, 2'd0},
    {6'd5,  6'd3,  6'd9,  2'd0, 2'd0},
    {6'd3,  6'd2,  6'd1,  2'd0, 2'd0},
    {6'd9,  6'd3,  6'd5,  2'd1, 2'd2},
    {6'd0,  6'd63, 6'd63, 2'd2, 2'd0},
    {6'd0,  6'd0,  6'd0,  2'd3, 2'd3},
    {6'd22, 6'd7,  6'd40, 2'd1, 2'd0},
    {6'd12, 6'd30, 6'd12, 2'd0, 2'd1}
  };

  logic                 clk, rst_n;
  logic                 in_valid, in_ready;
  logic [NUM*LLR_W-1:0] in_llr;
  logic [SYM_W-1:0]     in_syn, in_hard;
  logic                 out_valid, out_ready, out_last;
  logic [SYM_W-1:0]     out_sym;
  logic [LLR_W-1:0]     out_llr;

  int n_chk = 0;
  int n_bad = 0;
  int exp_v [Q];
  bit finished = 0;

  mmb_minmax_basis #(.SYM_W(SYM_W), .LLR_W(LLR_W)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_llr(in_llr), .in_syn(in_syn), .in_hard(in_hard),
    .out_valid(out_valid), .out_ready(out_ready), .out_sym(out_sym),
    .out_llr(out_llr), .out_last(out_last)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  // Reference built from the requirements: stable ascending order, greedy
  // independence by subset search, max over the decomposition, re-index.
  task automatic model(input logic [VEC_W-1:0] v);
    int llr [Q];
    int ord [NUM];
    int bs [SYM_W];
    int bl [SYM_W];
    int vh [Q];
    int nb, key, c, x, mx, t;
    bit rep;
    key = int'(v[2*SYM_W-1:SYM_W] ^ v[SYM_W-1:0]);
    llr[0] = 0;
    for (int b = 1; b < Q; b++) llr[b] = int'(v[2*SYM_W + (b-1)*LLR_W +: LLR_W]);
    for (int k = 0; k < NUM; k++) ord[k] = k + 1;
    for (int k = 1; k < NUM; k++) begin
      for (int j = k; j > 0; j--) begin
        if (llr[ord[j-1]] > llr[ord[j]]) begin
          t = ord[j]; ord[j] = ord[j-1]; ord[j-1] = t;
        end
      end
    end
    nb = 0;
    for (int k = 0; k < NUM; k++) begin
      c = ord[k];
      rep = 0;
      for (int m = 0; m < (1 << nb); m++) begin
        x = 0;
        for (int s = 0; s < nb; s++) if (((m >> s) & 1) != 0) x = x ^ bs[s];
        if (x == c) rep = 1;
      end
      if (!rep && nb < SYM_W) begin
        bs[nb] = c; bl[nb] = llr[c]; nb++;
      end
    end
    for (int b = 0; b < Q; b++) vh[b] = 0;
    for (int m = 1; m < (1 << nb); m++) begin
      x = 0; mx = 0;
      for (int s = 0; s < nb; s++) begin
        if (((m >> s) & 1) != 0) begin
          x = x ^ bs[s];
          if (bl[s] > mx) mx = bl[s];
        end
      end
      vh[x] = mx;
    end
    for (int a = 0; a < Q; a++) exp_v[a] = vh[a ^ key];
  endtask

  task automatic drive(input logic [VEC_W-1:0] v);
    in_llr  = v[VEC_W-1 -: NUM*LLR_W];
    in_syn  = v[2*SYM_W-1:SYM_W];
    in_hard = v[SYM_W-1:0];
  endtask

  // Called at a negedge with in_valid high; returns at a negedge with out_valid high.
  task automatic await_output();
    int lat;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    lat = 1;
    while (!out_valid && lat < 20) begin
      @(negedge clk);
      lat++;
    end
    check("R3 latency", lat, 4);
  endtask

  task automatic send(input logic [VEC_W-1:0] v);
    drive(v);
    in_valid = 1'b1;
    await_output();
  endtask

  task automatic collect(input string tag, input bit stall);
    logic [SYM_W-1:0] h_sym;
    logic [LLR_W-1:0] h_llr;
    logic             h_last;
    for (int a = 0; a < Q; a++) begin
      if (stall) begin
        out_ready = 1'b0;
        h_sym = out_sym; h_llr = out_llr; h_last = out_last;
        @(negedge clk);
        check("R6 held sym", int'(out_sym), int'(h_sym));
        check("R6 held llr", int'(out_llr), int'(h_llr));
        check("R6 held last", int'(out_last), int'(h_last));
        out_ready = 1'b1;
      end
      check("R4 valid", int'(out_valid), 1);
      check("R2 busy", int'(in_ready), 0);
      check("R4 order", int'(out_sym), a);
      check(tag, int'(out_llr), exp_v[a]);
      check("R5 last", int'(out_last), (a == Q-1) ? 1 : 0);
      @(negedge clk);
    end
    check("R2 idle after job", int'(in_ready), 1);
    check("R4 beat count", int'(out_valid), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    report();
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b1;
    in_llr = '0; in_syn = '0; in_hard = '0;
    repeat (3) @(negedge clk);
    check("R1 out_valid in reset", int'(out_valid), 0);
    check("R1 in_ready in reset", int'(in_ready), 1);
    check("R1 out_last in reset", int'(out_last), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 out_valid after reset", int'(out_valid), 0);

    // Vector table walk.
    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = (i == 1) ? "R7 sorted basis" : (i == 2) ? "R8 dependent skip" :
            (i >= 3) ? "R10 remap" : "R9 max decomposition";
      model(VECS[i]);
      send(VECS[i]);
      collect(tag, i[0]);
    end

    // Directed, hand-computed values.
    exp_v = '{0, 5, 3, 5};
    send(VECS[1]);
    collect("R7 explicit", 1'b0);
    exp_v = '{0, 1, 2, 2};
    send(VECS[2]);
    collect("R8 explicit", 1'b0);
    exp_v = '{5, 3, 5, 0};
    send(VECS[3]);
    collect("R10 explicit", 1'b1);
    exp_v = '{0, 5, 3, 5};
    send(VECS[0]);
    collect("R9 explicit", 1'b0);

    // R11: second job held on the input during a busy job.
    model(VECS[0]);
    send(VECS[0]);
    drive(VECS[6]);
    in_valid = 1'b1;
    collect("R11 first job intact", 1'b1);
    model(VECS[6]);
    await_output();
    collect("R11 held job", 1'b0);

    // Stall on the final beat only.
    model(VECS[7]);
    send(VECS[7]);
    for (int a = 0; a < Q-1; a++) @(negedge clk);
    out_ready = 1'b0;
    repeat (2) @(negedge clk);
    check("R5 last waits", int'(out_last), 1);
    check("R6 last value", int'(out_llr), exp_v[Q-1]);
    out_ready = 1'b1;
    @(negedge clk);
    check("R2 ready after last", int'(in_ready), 1);

    report();
  end
endmodule